// File: doc/BRIEF.md
# Learning Switch Output Port Lookup

This block is the forwarding stage of a small Ethernet switch datapath. It sits between the input arbiter and the output queues. It receives packets as an AXI4-Stream whose user sideband holds a per-packet metadata word. From the first beat it reads the destination and source MAC addresses, and from the metadata it reads the ingress port. It then searches a small learned address table for the destination and writes the chosen egress port set back into the metadata. In the same pass it records which port the source address was seen on.

Ports are one-hot in an 8-bit field. The four physical Ethernet ports use the even bits and the host path uses the odd bits. Destinations that are unknown or broadcast are flooded to every physical port except the ingress one. A destination learned on the packet's own ingress port yields an empty egress set, which the queues downstream treat as a drop. The head beat is held upstream while the search runs. All other beats, and every payload bit, pass through a single output register that obeys the downstream ready signal.

Top module: `lsw_port_lookup`

## Requirements
- R1: After reset the output is idle (`m_tvalid` low), `s_tready` is low, and the address table is empty, so the first packet seen is flooded.
- R2: The head beat carries the destination MAC in `tdata[47:0]` and the source MAC in `tdata[95:48]`. The metadata carries the length in `tuser[15:0]`, the ingress port in `tuser[23:16]` and the egress field in `tuser[31:24]`. Ports are one-hot, with physical ports on bits 0, 2, 4 and 6 and the host path on bits 1, 3, 5 and 7.
- R3: When the destination MAC is in the table under a port other than the ingress port, the egress field is that stored port.
- R4: When the destination MAC is absent, or is all ones (broadcast), the egress field is `8'h55` with the ingress bit cleared.
- R5: When the destination MAC is stored under exactly the ingress port, the egress field is zero and the packet is still passed on.
- R6: Every packet binds its source MAC to its ingress port. An address already present has its port replaced in place, with no second entry made.
- R7: The table holds 16 entries and never holds the same MAC twice. Once it is full, a new address overwrites the entry that was written longest ago (round-robin order).
- R8: The destination search sees the table as it stood before the current packet's own learning. A packet whose destination equals its not-yet-known source is therefore flooded.
- R9: Data, `tlast` and all metadata bits other than the egress field of the head beat leave exactly as they entered, in the same order.
- R10: `s_tready` stays low for at least two cycles after a head beat appears. Later beats move whenever the output register is empty or being drained. A stalled output keeps its data stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_tdata | input | 128 | Ingress stream data |
| s_tuser | input | 48 | Ingress metadata (length, ingress port, egress field, user bits) |
| s_tvalid | input | 1 | Ingress beat valid |
| s_tready | output | 1 | Ingress beat accepted |
| s_tlast | input | 1 | Last beat of packet |
| m_tdata | output | 128 | Egress stream data |
| m_tuser | output | 48 | Egress metadata with the egress field rewritten |
| m_tvalid | output | 1 | Egress beat valid |
| m_tready | input | 1 | Downstream ready |
| m_tlast | output | 1 | Last beat of packet |

## Verification
The destination search and the source learning write fall in the same cycle, and they collide when a packet's destination MAC equals its own source MAC. The bench sends such a packet twice from a host port. The first copy has to be flooded, because the search must see the table from before the write. The second copy has to get an empty egress field, because the address is now stored under the ingress port. A long sweep over a rotating pool of addresses adds evictions, in-place port moves and broadcast destinations, with random downstream stalls. It judges each egress field against a reference table kept in the bench.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

  localparam int MAC_W = 48;

  typedef logic [MAC_W-1:0] mac_t;

  typedef enum logic [1:0] {
    ST_HEAD = 2'd0,   // waiting for a head beat, upstream stalled
    ST_LKUP = 2'd1,   // table search and learning write
    ST_EMIT = 2'd2,   // head beat accepted with rewritten metadata
    ST_BODY = 2'd3    // remaining beats pass through
  } ctl_state_e;

  // Even bit positions mark physical ports.
  function automatic logic [63:0] phys_mask(input int w);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < w && i < 64; i += 2) m[i] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/lsw_mac_table.sv
module lsw_mac_table
  import lsw_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  // search port
  input  mac_t              lk_mac,
  output logic              lk_hit,
  output logic [PORT_W-1:0] lk_port,
  // learning port
  input  logic              ln_en,
  input  mac_t              ln_mac,
  input  logic [PORT_W-1:0] ln_port
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [DEPTH-1:0]  ent_vld;
  mac_t              ent_mac  [DEPTH];
  logic [PORT_W-1:0] ent_port [DEPTH];
  logic [IDX_W-1:0]  wr_ptr;

  logic [DEPTH-1:0]  lk_match;
  logic [DEPTH-1:0]  ln_match;
  logic [IDX_W-1:0]  ln_idx;
  logic              ln_found;

  // Parallel compare across all entries for both ports.
  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign lk_match[g] = ent_vld[g] && (ent_mac[g] == lk_mac);
      assign ln_match[g] = ent_vld[g] && (ent_mac[g] == ln_mac);
    end
  endgenerate

  always_comb begin
    lk_port = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (lk_match[i]) lk_port = lk_port | ent_port[i];
    end
  end

  assign lk_hit = |lk_match;

  always_comb begin
    ln_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ln_match[i]) ln_idx = IDX_W'(i);
    end
  end

  assign ln_found = |ln_match;

  // Valid bits and the replacement pointer carry reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      ent_vld <= '0;
      wr_ptr  <= '0;
    end else if (ln_en && !ln_found) begin
      ent_vld[wr_ptr] <= 1'b1;
      wr_ptr          <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
    end
  end

  // Payload arrays have no reset: plain write-enabled storage.
  always_ff @(posedge clk) begin
    if (ln_en) begin
      if (ln_found) begin
        ent_port[ln_idx] <= ln_port;
      end else begin
        ent_mac[wr_ptr]  <= ln_mac;
        ent_port[wr_ptr] <= ln_port;
      end
    end
  end

  // R7: no address is ever stored twice
  p_no_dup_lk_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match));
  p_no_dup_ln_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ln_match));

  // R6: an address just learned is found by the learning compare next cycle
  p_learn_sticks_r6: assert property (@(posedge clk) disable iff (rst)
    ln_en ##1 (ln_mac == $past(ln_mac)) |-> ln_found);

endmodule

// File: rtl/lsw_fwd_decide.sv
module lsw_fwd_decide
  import lsw_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  mac_t              dst_mac,
  input  logic              hit,
  input  logic [PORT_W-1:0] hit_port,
  input  logic [PORT_W-1:0] src_port,
  output logic [PORT_W-1:0] fwd
);

  localparam logic [63:0]       PM64 = phys_mask(PORT_W);
  localparam logic [PORT_W-1:0] PHYS = PM64[PORT_W-1:0];

  logic bcast;
  assign bcast = &dst_mac;

  always_comb begin
    if (bcast || !hit)          fwd = PHYS & ~src_port;
    else if (hit_port == src_port) fwd = '0;
    else                        fwd = hit_port;
  end

endmodule

// File: rtl/lsw_port_lookup.sv
module lsw_port_lookup
  import lsw_pkg::*;
#(
  parameter int DATA_W    = 128,
  parameter int USER_W    = 48,
  parameter int LEN_W     = 16,
  parameter int PORT_W    = 8,
  parameter int TBL_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic [USER_W-1:0] s_tuser,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic              s_tlast,
  output logic [DATA_W-1:0] m_tdata,
  output logic [USER_W-1:0] m_tuser,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic              m_tlast
);

  localparam int SRC_LO = LEN_W;
  localparam int DST_LO = LEN_W + PORT_W;
  localparam logic [63:0]       PM64 = phys_mask(PORT_W);
  localparam logic [PORT_W-1:0] PHYS = PM64[PORT_W-1:0];

  ctl_state_e        st;
  mac_t              pr_dmac, pr_smac;
  logic [PORT_W-1:0] pr_sport;
  logic              tb_hit;
  logic [PORT_W-1:0] tb_port;
  logic [PORT_W-1:0] fwd_c, fwd_q;
  logic              out_free, take, m_first;
  logic [USER_W-1:0] user_patched;

  assign out_free = !m_tvalid || m_tready;
  assign s_tready = ((st == ST_EMIT) || (st == ST_BODY)) && out_free;
  assign take     = s_tvalid && s_tready;

  // Control sequence: head wait, search, emit head, body.
  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_HEAD;
    end else begin
      unique case (st)
        ST_HEAD: if (s_tvalid) st <= ST_LKUP;
        ST_LKUP: st <= ST_EMIT;
        ST_EMIT: if (take) st <= s_tlast ? ST_HEAD : ST_BODY;
        ST_BODY: if (take && s_tlast) st <= ST_HEAD;
        default: st <= ST_HEAD;
      endcase
    end
  end

  // Header capture while the head beat waits upstream.
  always_ff @(posedge clk) begin
    if (st == ST_HEAD && s_tvalid) begin
      pr_dmac  <= s_tdata[MAC_W-1:0];
      pr_smac  <= s_tdata[2*MAC_W-1:MAC_W];
      pr_sport <= s_tuser[SRC_LO +: PORT_W];
    end
  end

  // Search and learning share the ST_LKUP cycle; the search sees old contents.
  lsw_mac_table #(
    .DEPTH  (TBL_DEPTH),
    .PORT_W (PORT_W)
  ) u_table (
    .clk     (clk),
    .rst     (rst),
    .lk_mac  (pr_dmac),
    .lk_hit  (tb_hit),
    .lk_port (tb_port),
    .ln_en   (st == ST_LKUP),
    .ln_mac  (pr_smac),
    .ln_port (pr_sport)
  );

  lsw_fwd_decide #(
    .PORT_W (PORT_W)
  ) u_decide (
    .dst_mac  (pr_dmac),
    .hit      (tb_hit),
    .hit_port (tb_port),
    .src_port (pr_sport),
    .fwd      (fwd_c)
  );

  always_ff @(posedge clk) begin
    if (st == ST_LKUP) fwd_q <= fwd_c;
  end

  always_comb begin
    user_patched = s_tuser;
    user_patched[DST_LO +: PORT_W] = fwd_q;
  end

  // Registered egress stage.
  always_ff @(posedge clk) begin
    if (rst)           m_tvalid <= 1'b0;
    else if (take)     m_tvalid <= 1'b1;
    else if (m_tready) m_tvalid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (take) begin
      m_tdata <= s_tdata;
      m_tlast <= s_tlast;
      m_tuser <= (st == ST_EMIT) ? user_patched : s_tuser;
      m_first <= (st == ST_EMIT);
    end
  end

  // R10: a stalled egress beat keeps its contents
  p_hold_stable_r10: assert property (@(posedge clk) disable iff (rst)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tuser)
                              && $stable(m_tlast));

  // R5: a head beat never names its own ingress port as egress
  p_no_reflect_r5: assert property (@(posedge clk) disable iff (rst)
    m_tvalid && m_first |->
      ((m_tuser[DST_LO +: PORT_W] & m_tuser[SRC_LO +: PORT_W]) == '0));

  // R4: egress is either a single port or a subset of physical ports
  p_field_shape_r4: assert property (@(posedge clk) disable iff (rst)
    m_tvalid && m_first |->
      ($onehot0(m_tuser[DST_LO +: PORT_W]) ||
       ((m_tuser[DST_LO +: PORT_W] & ~PHYS) == '0)));

  // R10: head beat cannot be taken in the cycle right after it appears
  p_head_wait_r10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HEAD) && s_tvalid |=> !s_tready);

endmodule

// File: tb/lsw_port_lookup_tb.sv
module lsw_port_lookup_tb;

  localparam int DW = 128;
  localparam int UW = 48;
  localparam int NENT = 16;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] s_tdata = '0;
  logic [UW-1:0] s_tuser = '0;
  logic          s_tvalid = 1'b0;
  logic          s_tready;
  logic          s_tlast = 1'b0;
  logic [DW-1:0] m_tdata;
  logic [UW-1:0] m_tuser;
  logic          m_tvalid;
  logic          m_tready = 1'b0;
  logic          m_tlast;

  always #4 clk = ~clk;   // 125 MHz

  lsw_port_lookup u_dut (
    .clk(clk), .rst(rst),
    .s_tdata(s_tdata), .s_tuser(s_tuser), .s_tvalid(s_tvalid),
    .s_tready(s_tready), .s_tlast(s_tlast),
    .m_tdata(m_tdata), .m_tuser(m_tuser), .m_tvalid(m_tvalid),
    .m_tready(m_tready), .m_tlast(m_tlast)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int pkt_id = 0;
  logic bp_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    m_tready <= bp_en ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL watchdog R1 act=%0d exp=finished", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Reference table built from the requirements.
  logic [47:0] md_mac [NENT];
  logic [7:0]  md_port[NENT];
  logic        md_vld [NENT];
  int          md_ptr;

  task automatic model_clear();
    for (int i = 0; i < NENT; i++) md_vld[i] = 1'b0;
    md_ptr = 0;
  endtask

  function automatic logic [7:0] model_fwd(input logic [47:0] d, input logic [7:0] sp);
    if (d == BCAST) return 8'h55 & ~sp;
    for (int i = 0; i < NENT; i++)
      if (md_vld[i] && md_mac[i] == d) return (md_port[i] == sp) ? 8'h00 : md_port[i];
    return 8'h55 & ~sp;
  endfunction

  task automatic model_learn(input logic [47:0] s, input logic [7:0] sp);
    for (int i = 0; i < NENT; i++)
      if (md_vld[i] && md_mac[i] == s) begin md_port[i] = sp; return; end
    md_vld[md_ptr] = 1'b1; md_mac[md_ptr] = s; md_port[md_ptr] = sp;
    md_ptr = (md_ptr + 1) % NENT;
  endtask

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] beat(input int id, input int k,
                                         input logic [47:0] d, input logic [47:0] s);
    if (k == 0) return {32'(id), s, d};
    return {32'(id), 32'(k), 64'(id * 1000 + k)};
  endfunction

  task automatic do_reset();
    rst = 1'b1; s_tvalid = 1'b0; s_tlast = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    model_clear();
  endtask

  task automatic run_pkt(input logic [47:0] d, input logic [47:0] s,
                         input logic [7:0] sp, input int nb, input string rq);
    logic [7:0]  ef, got_f;
    logic [UW-1:0] ub;
    bit data_ok, user_ok, last_ok;
    int id, waits;
    ef = model_fwd(d, sp);
    model_learn(s, sp);
    pkt_id++; id = pkt_id;
    ub = {16'hC000 | 16'(id), 8'hA5, sp, 16'(nb * 16)};
    data_ok = 1; user_ok = 1; last_ok = 1; got_f = 8'hEE; waits = 0;
    fork
      begin
        for (int k = 0; k < nb; k++) begin
          @(negedge clk);
          s_tvalid = 1'b1; s_tdata = beat(id, k, d, s); s_tuser = ub;
          s_tlast = (k == nb - 1);
          #1;
          while (!s_tready) begin @(negedge clk); #1; if (k == 0) waits++; end
          @(posedge clk);
        end
        @(negedge clk); s_tvalid = 1'b0; s_tlast = 1'b0;
      end
      begin
        int k = 0;
        while (k < nb) begin
          @(negedge clk);
          if (m_tvalid && m_tready) begin
            if (m_tdata != beat(id, k, d, s)) data_ok = 0;
            if (m_tlast != (k == nb - 1)) last_ok = 0;
            if (k == 0) begin
              got_f = m_tuser[31:24];
              if ({m_tuser[47:32], m_tuser[23:0]} != {ub[47:32], ub[23:0]}) user_ok = 0;
            end else if (m_tuser != ub) user_ok = 0;
            k++;
          end
        end
      end
    join
    chk(got_f == ef, rq, "egress field", 128'(got_f), 128'(ef));
    chk(data_ok && user_ok && last_ok, "R9", "pass-through data/user/last",
        128'({data_ok, user_ok, last_ok}), 128'(3'b111));
    chk(waits >= 2, "R10", "head beat held", 128'(waits), 128'(2));
  endtask

  function automatic logic [47:0] pool_mac(input int i);
    return {16'h0A00, 16'(i), 16'(i * 37 + 5)};
  endfunction

  logic [47:0] mA, mB, mC, mD;

  initial begin
    mA = 48'h0000_0000_00A1; mB = 48'h0000_0000_00B2;
    mC = 48'h0000_0000_00C3; mD = 48'h0000_0000_00D4;
    do_reset();
    @(negedge clk);
    chk(!m_tvalid && !s_tready, "R1", "idle after reset",
        128'({m_tvalid, s_tready}), 128'(0));

    // R1 R4: empty table floods
    run_pkt(mB, mA, 8'h01, 3, "R1");
    // R2 R3: learned destination
    run_pkt(mA, mB, 8'h04, 2, "R2");
    run_pkt(mB, mC, 8'h10, 1, "R3");
    // R4: broadcast from a physical and a host port
    run_pkt(BCAST, mC, 8'h10, 2, "R4");
    run_pkt(BCAST, mD, 8'h08, 1, "R4");
    // R5: destination on ingress port
    run_pkt(mA, mC, 8'h01, 2, "R5");
    // R6: A moves to port 0x40, then is found there
    run_pkt(mB, mA, 8'h40, 1, "R6");
    run_pkt(mA, mB, 8'h04, 2, "R6");
    // R8: same-cycle search and learn, destination == own source
    run_pkt(48'h0000_0000_00E5, 48'h0000_0000_00E5, 8'h02, 2, "R8");
    run_pkt(48'h0000_0000_00E5, 48'h0000_0000_00E5, 8'h02, 1, "R5");

    // R7: fill, evict oldest, query survivors
    do_reset();
    for (int i = 0; i < 17; i++)
      run_pkt(BCAST, pool_mac(100 + i), 8'(1 << (i % 8)), 1, "R7");
    run_pkt(pool_mac(100), pool_mac(116), 8'h40, 1, "R7");
    run_pkt(pool_mac(101), pool_mac(116), 8'h40, 1, "R7");
    run_pkt(pool_mac(115), pool_mac(116), 8'h40, 1, "R7");

    // Sweep over a rotating address pool with stalls
    do_reset();
    for (int i = 0; i < 320; i++) begin
      logic [47:0] d;
      logic [7:0] sp, ef;
      string rq;
      bp_en = (i % 2) == 1;
      sp = 8'(1 << (i % 8));
      d = (i % 13 == 0) ? BCAST : pool_mac((i * 3 + 1) % 24);
      ef = model_fwd(d, sp);
      rq = (ef == 8'h00) ? "R5" : (ef == (8'h55 & ~sp)) ? "R4" : "R3";
      run_pkt(d, pool_mac((i * 7) % 24), sp, 1 + (i % 4), rq);
    end
    bp_en = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule